// File: doc/BRIEF.md
# Video Lock Status Hysteresis Filter

This block sits after the raw lock detectors of a video decoder and turns their noisy per-line indications into a steady lock status. On every line strobe it compares a qualified raw lock condition with the status it currently reports. It counts how many consecutive lines disagree with that status, and it changes the status only when the count reaches a programmable threshold. Separate thresholds apply in each direction. Acquiring lock is governed by one 3-bit code and losing lock by another, and both codes select from a non-linear scale that runs from a single line up to one hundred thousand lines.

The raw condition is built from horizontal lock. It can also require subcarrier lock, and it can be judged per field with a vertical-lock evaluation flag in place of purely line-by-line judgement. Besides the status, the block gives a one-cycle pulse when lock is lost and exposes its run counter.

Top module: `lock_filter`

## Requirements
- R1: While reset is asserted and right after it is released, `locked` is 0, `lostLock` is 0 and `runCount` is 0.
- R2: The qualified raw lock is `hLockRaw` when `scLockEn` is 0, and `hLockRaw & scLockRaw` when `scLockEn` is 1.
- R3: When `fieldEval` is 1, the qualified raw lock additionally requires `vLockField` to be 1. When `fieldEval` is 0, `vLockField` is ignored.
- R4: On a clock edge with `lineStb` high, `runCount` increments by one if the qualified raw lock differs from `locked`. It clears to 0 if the two agree.
- R5: On an edge with `lineStb` low, `runCount` and `locked` keep their values whatever the other inputs do.
- R6: Both 3-bit codes map to line thresholds: 000=1, 001=2, 010=5, 011=10, 100=100, 101=500, 110=1000, 111=100000. `runCount` is 17 bits wide.
- R7: While unlocked, `cilCode` sets the threshold. While locked, `colCode` sets it. On the line strobe at which the incremented count would reach the threshold, `locked` toggles and `runCount` returns to 0 at that same edge.
- R8: `lostLock` is high for exactly the one cycle after an edge where `locked` goes from 1 to 0. It stays low on a 0-to-1 change.
- R9: The threshold is taken from the code inputs at every compare, and the compare is "count+1 greater or equal". Lowering a code below the current count therefore toggles `locked` on the next disagreeing strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStb | input | 1 | One-cycle strobe per video line |
| hLockRaw | input | 1 | Raw horizontal lock |
| scLockRaw | input | 1 | Raw subcarrier lock |
| vLockField | input | 1 | Per-field vertical lock evaluation |
| cilCode | input | 3 | Count-into-lock code |
| colCode | input | 3 | Count-out-of-lock code |
| fieldEval | input | 1 | 1: judge lock over the field with vertical lock |
| scLockEn | input | 1 | 1: require subcarrier lock as well |
| locked | output | 1 | Debounced lock status |
| lostLock | output | 1 | One-cycle pulse on loss of lock |
| runCount | output | 17 | Consecutive disagreeing line count |

## Verification
The run counter appears at the ports on every cycle, so an increment, clear or hold that goes wrong shows in the cycle after the offending strobe. A count that drifts off by one, or a threshold decoded wrongly, shows as `locked` toggling one or more strobes early or late. That can be as much as 100000 lines later for the longest code. A status register that toggles without a strobe, or a pulse that fires on acquisition, is visible at the very next edge.

// File: rtl/lock_filter_pkg.sv
package lock_filter_pkg;
  localparam int CNT_W = 17;

  typedef struct packed {
    logic clr;
    logic inc;
  } cntCmd_t;

  function automatic logic [31:0] codeToLines(input logic [2:0] code);
    logic [31:0] lines;
    case (code)
      3'd0:    lines = 32'd1;
      3'd1:    lines = 32'd2;
      3'd2:    lines = 32'd5;
      3'd3:    lines = 32'd10;
      3'd4:    lines = 32'd100;
      3'd5:    lines = 32'd500;
      3'd6:    lines = 32'd1000;
      default: lines = 32'd100000;
    endcase
    return lines;
  endfunction
endpackage

// File: rtl/lock_filter_dp.sv
module lock_filter_dp
  import lock_filter_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  cntCmd_t       cmd,
  input  logic          lockedNow,
  input  logic [2:0]    cilCode,
  input  logic [2:0]    colCode,
  output logic          atLimit,
  output logic [CW-1:0] cntQ
);
  logic [31:0] thrSel;
  logic [31:0] nextCount;

  // Threshold follows the direction of the pending change
  always_comb begin
    thrSel    = lockedNow ? codeToLines(colCode) : codeToLines(cilCode);
    nextCount = 32'(cntQ) + 32'd1;
    atLimit   = nextCount >= thrSel;
  end

  always_ff @(posedge clk) begin
    if (!rstN)        cntQ <= '0;
    else if (cmd.clr) cntQ <= '0;
    else if (cmd.inc) cntQ <= cntQ + 1'b1;
  end

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.inc |=> cntQ == $past(cntQ) + 1'b1);
  p_count_clear_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clr |=> cntQ == '0);
  p_count_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cmd.inc && !cmd.clr) |=> $stable(cntQ));
endmodule

// File: rtl/lock_filter_ctrl.sv
module lock_filter_ctrl
  import lock_filter_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    lineStb,
  input  logic    hLockRaw,
  input  logic    scLockRaw,
  input  logic    vLockField,
  input  logic    fieldEval,
  input  logic    scLockEn,
  input  logic    atLimit,
  output cntCmd_t cmd,
  output logic    lockedQ,
  output logic    lostPulse
);
  logic qualLock;
  logic disagree;
  logic flip;

  always_comb begin
    qualLock = hLockRaw & (scLockEn ? scLockRaw : 1'b1)
                        & (fieldEval ? vLockField : 1'b1);
    disagree = qualLock != lockedQ;
    flip     = lineStb & disagree & atLimit;
    cmd.clr  = lineStb & (~disagree | atLimit);
    cmd.inc  = lineStb & disagree & ~atLimit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lockedQ   <= 1'b0;
      lostPulse <= 1'b0;
    end else begin
      lockedQ   <= lockedQ ^ flip;
      lostPulse <= flip & lockedQ;
    end
  end

  p_hold_without_line_r5: assert property (@(posedge clk) disable iff (!rstN)
    !lineStb |=> $stable(lockedQ));
  p_flip_at_limit_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lockedQ) |-> $past(atLimit && lineStb));
  p_lost_on_fall_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lockedQ) |-> lostPulse);
  p_lost_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    lostPulse |=> !lostPulse);
endmodule

// File: rtl/lock_filter.sv
module lock_filter
  import lock_filter_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             lineStb,
  input  logic             hLockRaw,
  input  logic             scLockRaw,
  input  logic             vLockField,
  input  logic [2:0]       cilCode,
  input  logic [2:0]       colCode,
  input  logic             fieldEval,
  input  logic             scLockEn,
  output logic             locked,
  output logic             lostLock,
  output logic [CNT_W-1:0] runCount
);
  cntCmd_t cmd;
  logic    atLimit;

  lock_filter_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .lineStb(lineStb),
    .hLockRaw(hLockRaw), .scLockRaw(scLockRaw), .vLockField(vLockField),
    .fieldEval(fieldEval), .scLockEn(scLockEn), .atLimit(atLimit),
    .cmd(cmd), .lockedQ(locked), .lostPulse(lostLock)
  );

  lock_filter_dp #(.CW(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .lockedNow(locked),
    .cilCode(cilCode), .colCode(colCode),
    .atLimit(atLimit), .cntQ(runCount)
  );

  p_no_pulse_on_gain_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> !lostLock);
endmodule

// File: tb/lock_filter_tb.sv
module lock_filter_tb;
  typedef struct {
    logic        lk;
    logic        lost;
    logic [16:0] cnt;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStb = 1'b0, hLockRaw = 1'b0, scLockRaw = 1'b0, vLockField = 1'b0;
  logic [2:0] cilCode = 3'd3, colCode = 3'd3;
  logic fieldEval = 1'b0, scLockEn = 1'b0;
  logic locked, lostLock;
  logic [16:0] runCount;

  logic [2:0] tCil = 3'd3, tCol = 3'd3;
  logic tFe = 1'b0, tSe = 1'b0;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;
  logic mLocked = 1'b0;
  int mCnt = 0;

  always #2 clk = ~clk;

  lock_filter u_dut (
    .clk(clk), .rstN(rstN), .lineStb(lineStb), .hLockRaw(hLockRaw),
    .scLockRaw(scLockRaw), .vLockField(vLockField), .cilCode(cilCode),
    .colCode(colCode), .fieldEval(fieldEval), .scLockEn(scLockEn),
    .locked(locked), .lostLock(lostLock), .runCount(runCount)
  );

  function automatic int lines(input logic [2:0] c);
    int t[8] = '{1, 2, 5, 10, 100, 500, 1000, 100000};
    return t[c];
  endfunction

  // Driver: applies one cycle of stimulus and pushes the expected outcome
  task automatic step(input logic s, input logic h, input logic sc,
                      input logic v, input string tag);
    exp_t e;
    logic qual, pulse;
    @(negedge clk);
    lineStb = s; hLockRaw = h; scLockRaw = sc; vLockField = v;
    cilCode = tCil; colCode = tCol; fieldEval = tFe; scLockEn = tSe;
    qual  = h & (tSe ? sc : 1'b1) & (tFe ? v : 1'b1);
    pulse = 1'b0;
    if (s) begin
      if (qual == mLocked) mCnt = 0;
      else if (mCnt + 1 >= lines(mLocked ? tCol : tCil)) begin
        pulse = mLocked; mLocked = ~mLocked; mCnt = 0;
      end else mCnt++;
    end
    e.lk = mLocked; e.lost = pulse; e.cnt = 17'(mCnt); e.tag = tag;
    q.push_back(e);
  endtask

  task automatic run(input int n, input logic h, input logic sc,
                     input logic v, input string tag);
    for (int i = 0; i < n; i++) step(1'b1, h, sc, v, tag);
  endtask

  // Monitor: pops expectations just after each active edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      checks++;
      if (locked !== e.lk || lostLock !== e.lost || runCount !== e.cnt) begin
        errors++;
        $display("FAIL %s: locked/lost/count got %0b/%0b/%0d expected %0b/%0b/%0d",
                 e.tag, locked, lostLock, runCount, e.lk, e.lost, e.cnt);
      end
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete, got hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;  // R1 during reset
    if (locked !== 1'b0 || lostLock !== 1'b0 || runCount !== 17'd0) begin
      errors++;
      $display("FAIL R1: got %0b/%0b/%0d expected 0/0/0", locked, lostLock, runCount);
    end
    rstN = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, "R1");
    // R7: ten lock lines needed with code 011
    run(10, 1'b1, 1'b0, 1'b0, "R7");
    // R4: disagreement run broken by an agreeing line
    run(4, 1'b0, 1'b0, 1'b0, "R4");
    run(1, 1'b1, 1'b0, 1'b0, "R4");
    // R5: no strobe, inputs toggle, nothing moves
    run(3, 1'b0, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 6; i++) step(1'b0, 1'(i % 2), 1'b1, 1'b1, "R5");
    // R8: finish losing lock, then pulse must drop
    run(7, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R8");
    // R2: subcarrier qualifier
    tSe = 1'b1; tCil = 3'd0;
    run(12, 1'b1, 1'b0, 1'b0, "R2");
    run(1, 1'b1, 1'b1, 1'b0, "R2");
    // R6: code 001 out of lock, subcarrier loss alone drops lock
    tCol = 3'd1;
    run(2, 1'b1, 1'b0, 1'b0, "R6");
    // R3: field evaluation
    tSe = 1'b0; tFe = 1'b1; tCol = 3'd0;
    run(3, 1'b1, 1'b0, 1'b0, "R3");
    run(1, 1'b1, 1'b0, 1'b1, "R3");
    run(1, 1'b1, 1'b0, 1'b0, "R3");
    tFe = 1'b0;
    run(2, 1'b1, 1'b0, 1'b0, "R3");
    tCol = 3'd4;
    run(100, 1'b0, 1'b0, 1'b0, "R6");
    tCil = 3'd2;
    run(5, 1'b1, 1'b0, 1'b0, "R6");
    tCol = 3'd0;
    run(1, 1'b0, 1'b0, 1'b0, "R6");
    // R9: lower the code below the running count
    tCil = 3'd5;
    run(50, 1'b1, 1'b0, 1'b0, "R9");
    tCil = 3'd2;
    run(1, 1'b1, 1'b0, 1'b0, "R9");
    // R6: long codes
    tCol = 3'd5;
    run(500, 1'b0, 1'b0, 1'b0, "R6");
    tCil = 3'd6;
    run(1000, 1'b1, 1'b0, 1'b0, "R6");
    tCol = 3'd0;
    run(1, 1'b0, 1'b0, 1'b0, "R6");
    tCil = 3'd7;
    run(100000, 1'b1, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R6");
    repeat (3) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule